// File: doc/BRIEF.md
# Configuration Cycle Redirector

This block sits between a host's simple request port and two downstream ports: an ordinary I/O port and a configuration-cycle port. A control register holds a target descriptor: cycle type, dword register number, function and device. It also holds two arming bits. While both arming bits are set, a host word access to byte offset 0 of the I/O window is not sent to the I/O port. It is issued instead as a configuration read or write to the target held in the register. Every other window offset, and every window access made while the block is disarmed, passes straight through to the I/O port.

Configuration writes are posted. The host gets its acknowledge at once, and a busy flag stays up until the configuration port answers or a programmable timeout expires. Software can poll the flag instead of waiting a fixed delay. A configuration read with no response inside the timeout returns all ones. The bus carries little-endian words. When the host is big-endian, a parameter reverses the byte lanes of configuration data. A type 0 cycle to one chosen device number is flagged so that it is steered to the card slot instead of the primary bus.

Top module: `cfg_cycle_redirect`

## Requirements
- R1: Control register layout (host access with `hst_win_i`=0): bits [1:0] cycle type, [7:2] register number, [10:8] function, [15:11] device, bit 30 use-register, bit 31 config-select. A configuration cycle drives these fields unchanged on `cfg_type_o`, `cfg_reg_o`, `cfg_func_o` and `cfg_dev_o`.
- R2: A window access at offset 0 becomes a configuration cycle only when bits 30 and 31 are both set. With only one of them set, it goes to the I/O port.
- R3: Writing zero to the control register disarms the block, and later offset-0 window accesses go to the I/O port. A read of the control register then returns 0.
- R4: While the block is armed, window accesses at nonzero offsets go to the I/O port, and no configuration cycle is issued.
- R5: With `SWAP_LANES`=1, configuration data has its byte lanes reversed in both directions: host byte k is bus byte 3-k. With `SWAP_LANES`=0, it passes unchanged.
- R6: `cfg_cardbus_o` is 1 during a cycle exactly when the cycle type is 0 and the device equals `CB_DEV` (default 8). A type 1 cycle to the same device gives 0.
- R7: A configuration write is acknowledged to the host without waiting for the bus. `cfg_busy_o`, and bit 29 of the control register readback, are 1 from the cycle after acceptance until the bus acknowledge or the timeout.
- R8: A configuration request stays asserted for up to `tmo_lim_i`+1 cycles and accepts an acknowledge in any of them. If none arrives, the request drops, and a read returns 32'hFFFFFFFF.
- R9: A window access at offset 0 that arrives while a configuration cycle is still outstanding is held off until that cycle ends. It then runs as a configuration cycle of its own.
- R10: After reset the control register is 0, and `hst_ack_o`, `io_req_o`, `cfg_req_o` and `cfg_busy_o` are all 0.
- R11: The target fields are captured when a cycle starts. Rewriting the control register during a pending write does not change the fields on the configuration port.
- R12: An I/O access is forwarded with its offset, direction and data unchanged, with no lane reversal. The I/O port's read word is returned unchanged to the host.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tmo_lim_i | input | TMO_W | Configuration response timeout limit |
| hst_req_i | input | 1 | Host request, held until acknowledged |
| hst_we_i | input | 1 | Host write (1) or read (0) |
| hst_win_i | input | 1 | 1: I/O window, 0: control register |
| hst_addr_i | input | WIN_AW | Byte offset within the I/O window |
| hst_wdata_i | input | 32 | Host write data |
| hst_ack_o | output | 1 | One-cycle host acknowledge |
| hst_rdata_o | output | 32 | Host read data, valid with the acknowledge |
| io_req_o | output | 1 | I/O port request |
| io_we_o | output | 1 | I/O port write |
| io_addr_o | output | WIN_AW | I/O port offset |
| io_wdata_o | output | 32 | I/O port write data |
| io_ack_i | input | 1 | I/O port acknowledge |
| io_rdata_i | input | 32 | I/O port read data |
| cfg_req_o | output | 1 | Configuration port request |
| cfg_we_o | output | 1 | Configuration write |
| cfg_type_o | output | 2 | Cycle type |
| cfg_reg_o | output | 6 | Dword register number |
| cfg_func_o | output | 3 | Function number |
| cfg_dev_o | output | 5 | Device number |
| cfg_cardbus_o | output | 1 | Route this cycle to the card slot |
| cfg_wdata_o | output | 32 | Configuration write data (bus lane order) |
| cfg_ack_i | input | 1 | Configuration port acknowledge |
| cfg_rdata_i | input | 32 | Configuration read data (bus lane order) |
| cfg_busy_o | output | 1 | Posted configuration write outstanding |

## Verification
The bench builds the block with `SWAP_LANES`=1, a 4-bit window offset, a 4-bit timeout counter and a timeout limit of 6. With lane reversal enabled, every configuration data check tells a swapped word apart from a straight one, while the I/O checks confirm the path that must not swap. The short limit lets one test put the bus acknowledge on the last accepted cycle and another on no cycle at all, and a posted write can still span the host accesses that rewrite the register and poll the busy bit. `CB_DEV` keeps its default of 8, so the slot flag is tested with both cycle types.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
  localparam int BUSY_BIT = 29;
  localparam int USE_BIT  = 30;
  localparam int SEL_BIT  = 31;

  typedef struct packed {
    logic [4:0] dev;
    logic [2:0] func;
    logic [5:0] regn;
    logic [1:0] ctype;
  } cfg_tgt_t;

  typedef enum logic [1:0] {ST_IDLE, ST_IO, ST_CFG, ST_RESP} rt_state_e;

  function automatic logic [31:0] lane_rev(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction
endpackage

// File: rtl/cfgx_addr_reg.sv
module cfgx_addr_reg
  import cfgx_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  input  logic        busy_i,
  output cfg_tgt_t    tgt_o,
  output logic        armed_o,
  output logic [31:0] rdback_o
);
  cfg_tgt_t tgt_q;
  logic     use_q, sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q <= '0;
      use_q <= 1'b0;
      sel_q <= 1'b0;
    end else if (wr_i) begin
      tgt_q <= wdata_i[15:0];
      use_q <= wdata_i[USE_BIT];
      sel_q <= wdata_i[SEL_BIT];
    end
  end

  assign tgt_o    = tgt_q;
  assign armed_o  = use_q & sel_q;
  assign rdback_o = {sel_q, use_q, busy_i, 13'b0, tgt_q};
endmodule

// File: rtl/cfgx_engine.sv
module cfgx_engine
  import cfgx_pkg::*;
#(
  parameter int TMO_W      = 8,
  parameter int CB_DEV     = 8,
  parameter bit SWAP_LANES = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TMO_W-1:0] tmo_lim_i,
  input  logic             start_i,
  input  logic             we_i,
  input  logic [31:0]      wdata_i,
  input  cfg_tgt_t         tgt_i,
  output logic             bus_req_o,
  output logic             bus_we_o,
  output logic [31:0]      bus_wdata_o,
  output cfg_tgt_t         bus_tgt_o,
  output logic             bus_cardbus_o,
  input  logic             bus_ack_i,
  input  logic [31:0]      bus_rdata_i,
  output logic             active_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [31:0]      rdata_o
);
  localparam logic [4:0] CB_DEV_V = 5'(CB_DEV);

  logic [31:0]      wd_lane, rd_lane;
  logic             act_q, we_q, done_q;
  logic [31:0]      wd_q, rdata_q;
  cfg_tgt_t         tgt_q;
  logic [TMO_W-1:0] cnt_q;
  logic             tmo_hit;

  if (SWAP_LANES) begin : g_swap
    assign wd_lane = lane_rev(wdata_i);
    assign rd_lane = lane_rev(bus_rdata_i);
  end else begin : g_straight
    assign wd_lane = wdata_i;
    assign rd_lane = bus_rdata_i;
  end

  assign tmo_hit = act_q && !bus_ack_i && (cnt_q == tmo_lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= 1'b0;
      we_q    <= 1'b0;
      done_q  <= 1'b0;
      wd_q    <= '0;
      rdata_q <= '0;
      tgt_q   <= '0;
      cnt_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!act_q) begin
        if (start_i) begin
          act_q <= 1'b1;
          we_q  <= we_i;
          wd_q  <= wd_lane;
          tgt_q <= tgt_i;
          cnt_q <= '0;
        end
      end else if (bus_ack_i) begin
        act_q   <= 1'b0;
        done_q  <= 1'b1;
        rdata_q <= rd_lane;
      end else if (tmo_hit) begin
        act_q   <= 1'b0;
        done_q  <= 1'b1;
        rdata_q <= '1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign bus_req_o     = act_q;
  assign bus_we_o      = we_q;
  assign bus_wdata_o   = wd_q;
  assign bus_tgt_o     = tgt_q;
  assign bus_cardbus_o = (tgt_q.ctype == 2'd0) && (tgt_q.dev == CB_DEV_V);
  assign active_o      = act_q;
  assign busy_o        = act_q & we_q;
  assign done_o        = done_q;
  assign rdata_o       = rdata_q;

  assert_req_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ack_i && !tmo_hit) |=> bus_req_o);
  assert_cnt_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> (cnt_q <= tmo_lim_i));
  assert_fields_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ack_i && !tmo_hit) |=> ($stable(bus_tgt_o) && $stable(bus_wdata_o)));
  assert_busy_end_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> ($past(bus_ack_i) || $past(tmo_hit)));
endmodule

// File: rtl/cfgx_router.sv
module cfgx_router
  import cfgx_pkg::*;
#(
  parameter int WIN_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hst_req_i,
  input  logic              hst_we_i,
  input  logic              hst_win_i,
  input  logic [WIN_AW-1:0] hst_addr_i,
  input  logic [31:0]       hst_wdata_i,
  output logic              hst_ack_o,
  output logic [31:0]       hst_rdata_o,
  input  logic              armed_i,
  input  logic [31:0]       reg_rdback_i,
  output logic              reg_wr_o,
  input  logic              eng_active_i,
  input  logic              eng_done_i,
  input  logic [31:0]       eng_rdata_i,
  output logic              eng_start_o,
  output logic              io_req_o,
  output logic              io_we_o,
  output logic [WIN_AW-1:0] io_addr_o,
  output logic [31:0]       io_wdata_o,
  input  logic              io_ack_i,
  input  logic [31:0]       io_rdata_i
);
  rt_state_e         st_q;
  logic [31:0]       rdata_q, io_wd_q;
  logic [WIN_AW-1:0] io_addr_q;
  logic              io_we_q;
  logic              idle_req, cfg_hit;

  assign idle_req    = (st_q == ST_IDLE) && hst_req_i;
  assign cfg_hit     = hst_win_i && (hst_addr_i == '0) && armed_i;
  assign reg_wr_o    = idle_req && !hst_win_i && hst_we_i;
  assign eng_start_o = idle_req && cfg_hit && !eng_active_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      rdata_q   <= '0;
      io_wd_q   <= '0;
      io_addr_q <= '0;
      io_we_q   <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (hst_req_i) begin
          if (!hst_win_i) begin
            rdata_q <= reg_rdback_i;
            st_q    <= ST_RESP;
          end else if (cfg_hit) begin
            if (!eng_active_i) st_q <= hst_we_i ? ST_RESP : ST_CFG;
          end else begin
            io_addr_q <= hst_addr_i;
            io_we_q   <= hst_we_i;
            io_wd_q   <= hst_wdata_i;
            st_q      <= ST_IO;
          end
        end
        ST_IO: if (io_ack_i) begin
          rdata_q <= io_rdata_i;
          st_q    <= ST_RESP;
        end
        ST_CFG: if (eng_done_i) begin
          rdata_q <= eng_rdata_i;
          st_q    <= ST_RESP;
        end
        ST_RESP: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign hst_ack_o   = (st_q == ST_RESP);
  assign hst_rdata_o = rdata_q;
  assign io_req_o    = (st_q == ST_IO);
  assign io_we_o     = io_we_q;
  assign io_addr_o   = io_addr_q;
  assign io_wdata_o  = io_wd_q;

  assert_ack_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hst_ack_o |=> !hst_ack_o);
  assert_io_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_req_o && !io_ack_i) |=> (io_req_o && $stable(io_addr_o) && $stable(io_wdata_o)));
  assert_no_start_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_active_i |-> !eng_start_o);
endmodule

// File: rtl/cfg_cycle_redirect.sv
module cfg_cycle_redirect
  import cfgx_pkg::*;
#(
  parameter int WIN_AW     = 8,
  parameter int TMO_W      = 8,
  parameter int CB_DEV     = 8,
  parameter bit SWAP_LANES = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TMO_W-1:0]  tmo_lim_i,
  input  logic              hst_req_i,
  input  logic              hst_we_i,
  input  logic              hst_win_i,
  input  logic [WIN_AW-1:0] hst_addr_i,
  input  logic [31:0]       hst_wdata_i,
  output logic              hst_ack_o,
  output logic [31:0]       hst_rdata_o,
  output logic              io_req_o,
  output logic              io_we_o,
  output logic [WIN_AW-1:0] io_addr_o,
  output logic [31:0]       io_wdata_o,
  input  logic              io_ack_i,
  input  logic [31:0]       io_rdata_i,
  output logic              cfg_req_o,
  output logic              cfg_we_o,
  output logic [1:0]        cfg_type_o,
  output logic [5:0]        cfg_reg_o,
  output logic [2:0]        cfg_func_o,
  output logic [4:0]        cfg_dev_o,
  output logic              cfg_cardbus_o,
  output logic [31:0]       cfg_wdata_o,
  input  logic              cfg_ack_i,
  input  logic [31:0]       cfg_rdata_i,
  output logic              cfg_busy_o
);
  cfg_tgt_t    reg_tgt, bus_tgt;
  logic        armed, reg_wr, eng_start, eng_active, eng_busy, eng_done;
  logic [31:0] rdback, eng_rdata;

  cfgx_addr_reg u_addr_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (reg_wr),
    .wdata_i  (hst_wdata_i),
    .busy_i   (eng_busy),
    .tgt_o    (reg_tgt),
    .armed_o  (armed),
    .rdback_o (rdback)
  );

  cfgx_router #(.WIN_AW(WIN_AW)) u_router (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .hst_req_i    (hst_req_i),
    .hst_we_i     (hst_we_i),
    .hst_win_i    (hst_win_i),
    .hst_addr_i   (hst_addr_i),
    .hst_wdata_i  (hst_wdata_i),
    .hst_ack_o    (hst_ack_o),
    .hst_rdata_o  (hst_rdata_o),
    .armed_i      (armed),
    .reg_rdback_i (rdback),
    .reg_wr_o     (reg_wr),
    .eng_active_i (eng_active),
    .eng_done_i   (eng_done),
    .eng_rdata_i  (eng_rdata),
    .eng_start_o  (eng_start),
    .io_req_o     (io_req_o),
    .io_we_o      (io_we_o),
    .io_addr_o    (io_addr_o),
    .io_wdata_o   (io_wdata_o),
    .io_ack_i     (io_ack_i),
    .io_rdata_i   (io_rdata_i)
  );

  cfgx_engine #(.TMO_W(TMO_W), .CB_DEV(CB_DEV), .SWAP_LANES(SWAP_LANES)) u_engine (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tmo_lim_i     (tmo_lim_i),
    .start_i       (eng_start),
    .we_i          (hst_we_i),
    .wdata_i       (hst_wdata_i),
    .tgt_i         (reg_tgt),
    .bus_req_o     (cfg_req_o),
    .bus_we_o      (cfg_we_o),
    .bus_wdata_o   (cfg_wdata_o),
    .bus_tgt_o     (bus_tgt),
    .bus_cardbus_o (cfg_cardbus_o),
    .bus_ack_i     (cfg_ack_i),
    .bus_rdata_i   (cfg_rdata_i),
    .active_o      (eng_active),
    .busy_o        (eng_busy),
    .done_o        (eng_done),
    .rdata_o       (eng_rdata)
  );

  assign cfg_type_o = bus_tgt.ctype;
  assign cfg_reg_o  = bus_tgt.regn;
  assign cfg_func_o = bus_tgt.func;
  assign cfg_dev_o  = bus_tgt.dev;
  assign cfg_busy_o = eng_busy;

  assert_launch_armed_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_req_o) |-> $past(armed));
  assert_one_port_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(io_req_o) |-> !$rose(cfg_req_o));
endmodule

// File: tb/cfg_cycle_redirect_bench.sv
`timescale 1ns/1ps
module cfg_cycle_redirect_bench;
  localparam int AW = 4;
  localparam int TW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [TW-1:0] tmo_lim = 4'd6;
  logic          hst_req = 1'b0, hst_we = 1'b0, hst_win = 1'b0;
  logic [AW-1:0] hst_addr = '0;
  logic [31:0]   hst_wdata = '0;
  logic          hst_ack;
  logic [31:0]   hst_rdata;
  logic          io_req, io_we;
  logic [AW-1:0] io_addr;
  logic [31:0]   io_wdata;
  logic          io_ack = 1'b0;
  logic [31:0]   io_rdata = '0;
  logic          cfg_req, cfg_we, cfg_cardbus, cfg_busy;
  logic [1:0]    cfg_type;
  logic [5:0]    cfg_reg;
  logic [2:0]    cfg_func;
  logic [4:0]    cfg_dev;
  logic [31:0]   cfg_wdata;
  logic          cfg_ack = 1'b0;
  logic [31:0]   cfg_rdata = '0;

  int n_chk = 0, n_bad = 0;
  // responder settings and captures
  int          cfg_delay = 0;
  logic        cfg_mute = 1'b0;
  logic [31:0] cfg_word = 32'h11223344;
  logic [31:0] io_word = 32'hCAFE0042;
  int          cw = 0, n_cfg = 0, n_io = 0;
  logic [15:0] s_tgt = '0;
  logic        s_cb = 1'b0, s_we = 1'b0, s_iowe = 1'b0;
  logic [31:0] s_wd = '0, s_iowd = '0;
  logic [AW-1:0] s_ioaddr = '0;

  always #4 clk = ~clk;

  cfg_cycle_redirect #(.WIN_AW(AW), .TMO_W(TW), .CB_DEV(8), .SWAP_LANES(1'b1)) u_cfg_cycle_redirect (
    .clk_i(clk), .rst_ni(rst_n), .tmo_lim_i(tmo_lim),
    .hst_req_i(hst_req), .hst_we_i(hst_we), .hst_win_i(hst_win), .hst_addr_i(hst_addr),
    .hst_wdata_i(hst_wdata), .hst_ack_o(hst_ack), .hst_rdata_o(hst_rdata),
    .io_req_o(io_req), .io_we_o(io_we), .io_addr_o(io_addr), .io_wdata_o(io_wdata),
    .io_ack_i(io_ack), .io_rdata_i(io_rdata),
    .cfg_req_o(cfg_req), .cfg_we_o(cfg_we), .cfg_type_o(cfg_type), .cfg_reg_o(cfg_reg),
    .cfg_func_o(cfg_func), .cfg_dev_o(cfg_dev), .cfg_cardbus_o(cfg_cardbus),
    .cfg_wdata_o(cfg_wdata), .cfg_ack_i(cfg_ack), .cfg_rdata_i(cfg_rdata), .cfg_busy_o(cfg_busy)
  );

  always @(posedge clk) begin
    if (!cfg_req || cfg_ack) begin
      cw <= 0; cfg_ack <= 1'b0;
    end else if (!cfg_mute && cw == cfg_delay) begin
      cfg_ack <= 1'b1; cfg_rdata <= cfg_word; n_cfg <= n_cfg + 1;
      s_tgt <= {cfg_dev, cfg_func, cfg_reg, cfg_type};
      s_cb <= cfg_cardbus; s_we <= cfg_we; s_wd <= cfg_wdata;
    end else cw <= cw + 1;
  end

  always @(posedge clk) begin
    if (!io_req || io_ack) io_ack <= 1'b0;
    else begin
      io_ack <= 1'b1; io_rdata <= io_word; n_io <= n_io + 1;
      s_ioaddr <= io_addr; s_iowe <= io_we; s_iowd <= io_wdata;
    end
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic host(input logic win, input logic we, input logic [AW-1:0] addr,
                      input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    hst_req = 1'b1; hst_win = win; hst_we = we; hst_addr = addr; hst_wdata = wd;
    do @(negedge clk); while (!hst_ack);
    rd = hst_rdata;
    hst_req = 1'b0;
  endtask

  function automatic logic [31:0] mk(input logic sel, input logic use_r, input logic [4:0] dev,
                                     input logic [2:0] fn, input logic [5:0] rg, input logic [1:0] ty);
    return {sel, use_r, 14'b0, dev, fn, rg, ty};
  endfunction

  task automatic wait_idle();
    while (cfg_busy || cfg_req) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] rd;
    chk("R10 ack", 32'(hst_ack), 0);
    chk("R10 io_req", 32'(io_req), 0);
    chk("R10 cfg_req", 32'(cfg_req), 0);
    chk("R10 busy", 32'(cfg_busy), 0);
    host(0, 0, 0, 0, rd);
    chk("R10 ctl readback", rd, 0);
  endtask

  task automatic t_partial_arm();
    logic [31:0] rd;
    int c0, i0;
    c0 = n_cfg; i0 = n_io;
    host(0, 1, 0, mk(1, 0, 5'd3, 3'd1, 6'd4, 2'd0), rd);
    host(1, 0, 0, 0, rd);
    chk("R2 sel only goes to io", 32'(n_io - i0), 1);
    chk("R2 sel only io data", rd, io_word);
    host(0, 1, 0, mk(0, 1, 5'd3, 3'd1, 6'd4, 2'd0), rd);
    host(1, 0, 0, 0, rd);
    chk("R2 use only goes to io", 32'(n_io - i0), 2);
    chk("R2 no cfg cycles", 32'(n_cfg - c0), 0);
  endtask

  task automatic t_cfg_read();
    logic [31:0] rd;
    cfg_delay = 2; cfg_word = 32'h11223344;
    host(0, 1, 0, mk(1, 1, 5'd3, 3'd5, 6'h2A, 2'd1), rd);
    host(0, 0, 0, 0, rd);
    chk("R1 ctl readback", rd, mk(1, 1, 5'd3, 3'd5, 6'h2A, 2'd1));
    host(1, 0, 0, 0, rd);
    chk("R5 read lane reversal", rd, 32'h44332211);
    chk("R1 fields on port", 32'(s_tgt), 32'({5'd3, 3'd5, 6'h2A, 2'd1}));
    chk("R1 read direction", 32'(s_we), 0);
    chk("R6 type1 dev3 no cardbus", 32'(s_cb), 0);
    host(0, 1, 0, mk(1, 1, 5'd8, 3'd0, 6'd0, 2'd1), rd);
    host(1, 0, 0, 0, rd);
    chk("R6 type1 dev8 no cardbus", 32'(s_cb), 0);
    host(0, 1, 0, mk(1, 1, 5'd8, 3'd2, 6'd1, 2'd0), rd);
    host(1, 0, 0, 0, rd);
    chk("R6 type0 dev8 cardbus", 32'(s_cb), 1);
  endtask

  task automatic t_passthru();
    logic [31:0] rd;
    int c0;
    c0 = n_cfg;
    host(1, 1, 4'd4, 32'hA1B2C3D4, rd);
    chk("R12 io addr", 32'(s_ioaddr), 4);
    chk("R12 io we", 32'(s_iowe), 1);
    chk("R4 R12 io wdata unswapped", s_iowd, 32'hA1B2C3D4);
    io_word = 32'h0BADF00D;
    host(1, 0, 4'd8, 0, rd);
    chk("R12 io rdata unswapped", rd, 32'h0BADF00D);
    chk("R4 no cfg while armed offset nonzero", 32'(n_cfg - c0), 0);
  endtask

  task automatic t_posted();
    logic [31:0] rd;
    cfg_delay = 5;
    host(0, 1, 0, mk(1, 1, 5'd9, 3'd6, 6'h11, 2'd0), rd);
    host(1, 1, 0, 32'hA1B2C3D4, rd);
    chk("R7 busy after posted ack", 32'(cfg_busy), 1);
    host(0, 0, 0, 0, rd);
    chk("R7 busy bit in readback", 32'(rd[29]), 1);
    host(0, 1, 0, 0, rd);
    wait_idle();
    chk("R11 fields held", 32'(s_tgt), 32'({5'd9, 3'd6, 6'h11, 2'd0}));
    chk("R5 write lane reversal", s_wd, 32'hD4C3B2A1);
    chk("R7 write direction", 32'(s_we), 1);
    host(0, 0, 0, 0, rd);
    chk("R3 readback zero", rd, 0);
  endtask

  task automatic t_disarm();
    logic [31:0] rd;
    int c0, i0;
    c0 = n_cfg; i0 = n_io;
    io_word = 32'h00C0FFEE;
    host(1, 0, 0, 0, rd);
    chk("R3 disarmed goes to io", 32'(n_io - i0), 1);
    chk("R3 disarmed data", rd, 32'h00C0FFEE);
    chk("R3 no cfg", 32'(n_cfg - c0), 0);
  endtask

  task automatic t_stall();
    logic [31:0] rd;
    int c0;
    cfg_delay = 5; cfg_word = 32'hDEADBEEF;
    host(0, 1, 0, mk(1, 1, 5'd2, 3'd0, 6'd3, 2'd0), rd);
    c0 = n_cfg;
    host(1, 1, 0, 32'h01020304, rd);
    host(1, 0, 0, 0, rd);
    chk("R9 both cycles ran", 32'(n_cfg - c0), 2);
    chk("R9 stalled read data", rd, 32'hEFBEADDE);
    chk("R9 last cycle is read", 32'(s_we), 0);
  endtask

  task automatic t_timeout();
    logic [31:0] rd;
    int c0;
    cfg_delay = 5; cfg_word = 32'h0A0B0C0D;
    host(1, 0, 0, 0, rd);
    chk("R8 ack on last allowed cycle", rd, 32'h0D0C0B0A);
    cfg_mute = 1'b1;
    c0 = n_cfg;
    host(1, 0, 0, 0, rd);
    chk("R8 timeout read all ones", rd, 32'hFFFFFFFF);
    chk("R8 request dropped", 32'(cfg_req), 0);
    host(1, 1, 0, 32'h5, rd);
    repeat (9) @(negedge clk);
    chk("R8 R7 busy clears on timeout", 32'(cfg_busy), 0);
    chk("R8 no acks when muted", 32'(n_cfg - c0), 0);
    cfg_mute = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_partial_arm();
    t_cfg_read();
    t_passthru();
    t_posted();
    t_disarm();
    t_stall();
    t_timeout();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule